// File: doc/BRIEF.md
# Codec Frame Rate Timing Generator

This block paces the sample traffic between a host and an attached audio/telecom codec on a serial link. It produces two independent one-cycle request strobes, one for the audio channel and one for the telecom channel. Each strobe marks the moment the next outgoing sample must be supplied. Each channel's rate is the selected timing clock divided by 32 times a programmable divisor.

The timing clock is either the system clock itself (internal mode) or the rising edges of an external clock input. In external mode the edges pass through a synchronizer and a prescaler that divides them by 1, 2, 3 or 4. The prescaler is built as a clock-enable pulse on the system clock, not as a derived clock. A single 32-bit control word holds every field: the two divisors, the clock select, the prescaler code, the loopback request and the run enable. One write can program the whole block and start it. The loopback bit is passed out to the serial shifter, which is outside this block.

Top module: `codec_frame_timer`

## Requirements
- R1: After reset, the enable bit (bit 20 of the control word) reads 0, and neither strobe fires until the block is enabled.
- R2: A write loads every live field at once. Live fields: audio divisor bits 6..0, telecom divisor bits 14..8, clock select bit 16, prescaler code bits 18..17, loopback bit 19, enable bit 20. Readback returns the written live bits, and every other bit reads 0 whatever was written.
- R3: With audio divisor A in 6..127, consecutive audio strobes are 32×A timing ticks apart.
- R4: With telecom divisor T in 16..127, consecutive telecom strobes are 32×T timing ticks apart.
- R5: An audio divisor below 6 behaves exactly as 6, so the audio period is 192 ticks.
- R6: A telecom divisor below 16 behaves exactly as 16, so the telecom period is 512 ticks.
- R7: With clock select 0, every system cycle is a tick and the prescaler code has no effect.
- R8: With clock select 1, a tick occurs on every (code+1)-th rising edge of the external clock. Code 0 gives 1, code 1 gives 2, code 2 gives 3 and code 3 gives 4.
- R9: While enable is 0, no strobe fires and the counters are held at zero. In internal mode, the first strobe of each channel appears exactly 32×divisor cycles after the clock edge that wrote enable to 1.
- R10: The loopback output equals the loopback bit of the control word.
- R11: Each strobe is high for exactly one system cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_in | input | 1 | External timing clock, asynchronous to clk |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_data | input | 32 | Control word write value |
| reg_rd_data | output | 32 | Control word readback |
| audio_req | output | 1 | Audio sample request strobe |
| telecom_req | output | 1 | Telecom sample request strobe |
| loopback_en | output | 1 | Loopback request to the serial shifter |

## Verification
A counter holding a wrong value shows up as a strobe gap that differs from 32×divisor. In internal mode it also shifts the first strobe after enable away from its exact cycle, so a single period reveals it, at most 4064 cycles. A prescaler fault scales every external-mode gap by the wrong factor within two strobes. A wrong clamp shows up the first time a small divisor is programmed. A fault in the control register is visible on readback one cycle after the write.

// File: rtl/cft_pkg.sv
package cft_pkg;
    localparam int REG_W    = 32;
    localparam int DIV_W    = 7;
    localparam int SHIFT    = 5;
    localparam int PRE_W    = 2;
    localparam int CNT_W    = DIV_W + SHIFT;

    localparam int AUD_LSB  = 0;
    localparam int TEL_LSB  = 8;
    localparam int SEL_BIT  = 16;
    localparam int PRE_LSB  = 17;
    localparam int LOOP_BIT = 19;
    localparam int EN_BIT   = 20;

    typedef struct packed {
        logic             enable;
        logic             loopback;
        logic [PRE_W-1:0] pre;
        logic             ext_sel;
        logic [DIV_W-1:0] tel_div;
        logic [DIV_W-1:0] aud_div;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.aud_div  = w[AUD_LSB +: DIV_W];
        c.tel_div  = w[TEL_LSB +: DIV_W];
        c.ext_sel  = w[SEL_BIT];
        c.pre      = w[PRE_LSB +: PRE_W];
        c.loopback = w[LOOP_BIT];
        c.enable   = w[EN_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[AUD_LSB +: DIV_W] = c.aud_div;
        w[TEL_LSB +: DIV_W] = c.tel_div;
        w[SEL_BIT]          = c.ext_sel;
        w[PRE_LSB +: PRE_W] = c.pre;
        w[LOOP_BIT]         = c.loopback;
        w[EN_BIT]           = c.enable;
        return w;
    endfunction

    localparam logic [REG_W-1:0] LIVE_MASK = ctrl_pack('1);
endpackage

// File: rtl/cft_ctrl_reg.sv
module cft_ctrl_reg
    import cft_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctrl_t            ctrl,
    output logic [REG_W-1:0] rd_data
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = ctrl_unpack(wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl    = ctrl_q;
    assign rd_data = ctrl_pack(ctrl_q);
endmodule

// File: rtl/cft_prescaler.sv
module cft_prescaler
    import cft_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ext_sel,
    input  logic [PRE_W-1:0] pre_code,
    input  logic             ext_clk,
    output logic             tick
);
    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              prev;
        logic [PRE_W-1:0]  pcnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    rise;
    logic    wrap;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_N-2:0], ext_clk};
        st_d.prev = st_q.sync[SYNC_N-1];
        rise      = st_q.sync[SYNC_N-1] & ~st_q.prev;
        wrap      = (st_q.pcnt >= pre_code);
        tick      = 1'b0;
        if (!run) begin
            st_d.pcnt = '0;
        end else if (!ext_sel) begin
            tick = 1'b1;
        end else if (rise) begin
            if (wrap) begin
                st_d.pcnt = '0;
                tick      = 1'b1;
            end else begin
                st_d.pcnt = st_q.pcnt + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cft_rate_counter.sv
module cft_rate_counter
    import cft_pkg::*;
#(
    parameter int MIN_DIV = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [DIV_W-1:0] div,
    output logic             strobe
);
    localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stb;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [DIV_W-1:0] div_eff;
    logic [CNT_W-1:0] term;

    always_comb begin
        div_eff  = (div < MIN_V) ? MIN_V : div;
        term     = {div_eff, {SHIFT{1'b0}}} - CNT_W'(1);
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt >= term) begin
                st_d.cnt = '0;
                st_d.stb = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = st_q.stb;
endmodule

// File: rtl/codec_frame_timer.sv
module codec_frame_timer
    import cft_pkg::*;
#(
    parameter int AUD_MIN = 6,
    parameter int TEL_MIN = 16,
    parameter int SYNC_N  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_clk_in,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    output logic        audio_req,
    output logic        telecom_req,
    output logic        loopback_en
);
    localparam int N_CH = 2;

    ctrl_t            ctrl;
    logic             tick;
    logic [N_CH-1:0]  req;
    logic [DIV_W-1:0] ch_div [N_CH];

    cft_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .ctrl    (ctrl),
        .rd_data (reg_rd_data)
    );

    cft_prescaler #(.SYNC_N(SYNC_N)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl.enable),
        .ext_sel  (ctrl.ext_sel),
        .pre_code (ctrl.pre),
        .ext_clk  (ext_clk_in),
        .tick     (tick)
    );

    assign ch_div[0] = ctrl.aud_div;
    assign ch_div[1] = ctrl.tel_div;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        localparam int CH_MIN = (ch == 0) ? AUD_MIN : TEL_MIN;
        cft_rate_counter #(.MIN_DIV(CH_MIN)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (ctrl.enable),
            .tick   (tick),
            .div    (ch_div[ch]),
            .strobe (req[ch])
        );
    end

    assign audio_req   = req[0];
    assign telecom_req = req[1];
    assign loopback_en = ctrl.loopback;
endmodule

// File: rtl/cft_checker.sv
module cft_checker
    import cft_pkg::*;
#(
    parameter int AUD_MIN = 6,
    parameter int TEL_MIN = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [31:0] reg_wr_data,
    input logic [31:0] reg_rd_data,
    input logic        audio_req,
    input logic        telecom_req
);
    localparam int GAP_W = CNT_W + 1;
    localparam logic [GAP_W-1:0] A_LIM = GAP_W'(AUD_MIN * (1 << SHIFT) - 1);
    localparam logic [GAP_W-1:0] T_LIM = GAP_W'(TEL_MIN * (1 << SHIFT) - 1);

    logic [GAP_W-1:0] a_gap, t_gap;
    logic             a_seen, t_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_gap  <= '0;
            t_gap  <= '0;
            a_seen <= 1'b0;
            t_seen <= 1'b0;
        end else begin
            if (audio_req) begin
                a_gap  <= '0;
                a_seen <= 1'b1;
            end else if (a_gap != '1) begin
                a_gap <= a_gap + GAP_W'(1);
            end
            if (telecom_req) begin
                t_gap  <= '0;
                t_seen <= 1'b1;
            end else if (t_gap != '1) begin
                t_gap <= t_gap + GAP_W'(1);
            end
        end
    end

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data & ~LIVE_MASK) == '0); // R2
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> reg_rd_data == ($past(reg_wr_data) & LIVE_MASK)); // R2
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_data[EN_BIT] |=> (!audio_req && !telecom_req)); // R9
    AST_AUD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        audio_req |=> !audio_req); // R11
    AST_TEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        telecom_req |=> !telecom_req); // R11
    AST_AUD_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (audio_req && a_seen) |-> a_gap >= A_LIM); // R5
    AST_TEL_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (telecom_req && t_seen) |-> t_gap >= T_LIM); // R6
endmodule

bind codec_frame_timer cft_checker #(.AUD_MIN(AUD_MIN), .TEL_MIN(TEL_MIN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .audio_req   (audio_req),
    .telecom_req (telecom_req)
);

// File: tb/codec_frame_timer_tb.sv
module codec_frame_timer_tb;
    localparam logic [31:0] EN   = 32'h0010_0000;
    localparam logic [31:0] LIVE = 32'h001F_7F7F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        audio_req, telecom_req, loopback_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int a_ref = 0, t_ref = 0;
    bit expect_none = 1'b1;
    bit a_prev = 1'b0, t_prev = 1'b0;
    int q_a[$];
    int q_t[$];

    codec_frame_timer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_clk_in  (ext_clk),
        .reg_wr_en   (wr_en),
        .reg_wr_data (wr_data),
        .reg_rd_data (rd_data),
        .audio_req   (audio_req),
        .telecom_req (telecom_req),
        .loopback_en (loopback_en)
    );

    initial forever #4 clk = ~clk;
    initial begin
        #3;
        forever #16 ext_clk = ~ext_clk;
    end
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mk(input int aud, input int tel, input bit sel,
                                       input int pre, input bit loopb);
        return 32'(aud & 127) | (32'(tel & 127) << 8) | (32'(sel) << 16) |
               (32'(pre & 3) << 17) | (32'(loopb) << 19);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops the expected gap for each strobe and compares.
    always @(negedge clk) begin
        if (rst_n) begin
            if (a_prev) check("R11 audio width", audio_req, 0);
            if (t_prev) check("R11 telecom width", telecom_req, 0);
            if (audio_req && !a_prev) begin
                if (expect_none) check("R9 audio strobe while disabled", 1, 0);
                else if (q_a.size() > 0) begin
                    int e;
                    e = q_a.pop_front();
                    if (e >= 0) check("R3/R5/R7/R8 audio gap", cyc - a_ref, e);
                end
                a_ref = cyc;
            end
            if (telecom_req && !t_prev) begin
                if (expect_none) check("R9 telecom strobe while disabled", 1, 0);
                else if (q_t.size() > 0) begin
                    int e;
                    e = q_t.pop_front();
                    if (e >= 0) check("R4/R6 telecom gap", cyc - t_ref, e);
                end
                t_ref = cyc;
            end
            a_prev = audio_req;
            t_prev = telecom_req;
        end
    end

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Driver: pushes expected gaps, enables, waits for the scoreboard to drain.
    task automatic run_phase(input logic [31:0] cfg, input int na, input int ga,
                             input int nt, input int gt, input bit skip_first);
        int w;
        expect_none = 1'b0;
        for (int i = 0; i < na; i++) q_a.push_back((skip_first && i == 0) ? -1 : ga);
        for (int i = 0; i < nt; i++) q_t.push_back((skip_first && i == 0) ? -1 : gt);
        reg_write(cfg | EN);
        a_ref = cyc;
        t_ref = cyc;
        w = 0;
        while ((q_a.size() > 0 || q_t.size() > 0) && w < 60000) begin
            @(negedge clk);
            w++;
        end
        check("R3/R4 all expected strobes seen", q_a.size() + q_t.size(), 0);
        q_a.delete();
        q_t.delete();
        reg_write(cfg);
        @(negedge clk);
        expect_none = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 enable after reset", rd_data[20], 0);
        repeat (40) @(negedge clk);

        // R2 / R10: register fields, reserved bits, loopback output
        reg_write(32'hFFEF_FFFF);
        check("R2 readback all-ones minus enable", rd_data, 32'hFFEF_FFFF & LIVE);
        check("R10 loopback set", loopback_en, 1);
        repeat (200) @(negedge clk);
        check("R9 no strobe with enable 0", audio_req | telecom_req, 0);
        reg_write(32'h0000_0000);
        check("R2 readback zero", rd_data, 0);
        check("R10 loopback clear", loopback_en, 0);
        reg_write(mk(45, 99, 1, 2, 1));
        check("R2 mixed readback", rd_data, mk(45, 99, 1, 2, 1));

        // R3 R4 R9: minimum legal divisors, exact first-strobe latency
        run_phase(mk(6, 16, 0, 0, 0), 4, 192, 3, 512, 0);
        // R3 R4: large divisors
        run_phase(mk(100, 127, 0, 0, 0), 2, 3200, 2, 4064, 0);
        // R5 R6: clamping
        run_phase(mk(2, 5, 0, 0, 0), 3, 192, 2, 512, 0);
        run_phase(mk(0, 0, 0, 0, 0), 2, 192, 1, 512, 0);
        // R7: prescaler code ignored in internal mode
        run_phase(mk(10, 20, 0, 3, 0), 3, 320, 2, 640, 0);
        // R8: external clock, period 4 system cycles, code 0..3
        for (int p = 0; p < 4; p++) begin
            run_phase(mk(6, 16, 1, p, 0), 3, 4 * (p + 1) * 192, 0, 0, 1);
        end
        repeat (600) @(negedge clk);
        check("R9 silent after disable", audio_req | telecom_req, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule